// File: doc/BRIEF.md
# Programmable Sync-Hunt Serial Receiver

This block takes a bit-serial stream of unframed data, one bit per bit-clock strobe. It stays in a hunting state until it finds where character boundaries fall, then packs the bits that follow into bytes. A 2-bit length select picks how alignment is found. In one setting, a sync input pulse (or carrier detect) marks the first data bit. In the other three, a comparator looks for a 4-, 8- or 16-bit pattern taken from the low bits of a 16-bit sync word.

Once aligned, each completed byte appears on `rx_byte` with a one-cycle `rx_valid` strobe. The receiver stays aligned until software issues a hunt command or the block is disabled. In 4-bit mode the receiver can optionally drop repeats of the sync nibble that follow the match. When carrier detect is used as the sync source, it can be expected one bit late, on the second bit of the frame.

Top module: `sync_hunt_rx`

## Requirements
- R1: After reset, `aligned` and `rx_valid` are both 0.
- R2: With `len_sel`=00 and `cd_mode`=0, the receiver aligns on the first bit strobe where `ext_sync` is 1, and `sync_pat` plays no part. That bit is the first data bit.
- R3: With `len_sel`=01, the receiver aligns when the last 4 received bits equal `sync_pat[3:0]`. Bits are compared oldest first, in MSB position. Data starts with the next bit.
- R4: With `len_sel`=10, alignment uses the last 8 bits against `sync_pat[7:0]`.
- R5: With `len_sel`=11, alignment uses the last 16 bits against all of `sync_pat`. A match is only taken once at least as many bits as the pattern length have arrived since enable.
- R6: Bytes are assembled MSB first. `rx_valid` is high for exactly one cycle, in the cycle after the strobe that carried the eighth bit.
- R7: Once aligned, later sync patterns in the data are delivered as ordinary data. A `hunt_cmd` pulse or `en`=0 clears `aligned` by the next cycle.
- R8: With `len_sel`=01 and `strip_en`=1, each aligned 4-bit character that equals `sync_pat[3:0]` and directly follows the match (or a stripped repeat) is discarded.
- R9: Stripping ends for good at the first aligned nibble that differs from the pattern. That nibble becomes the high half of the first byte, and later pattern nibbles are delivered as data.
- R10: With `len_sel`=00 and `cd_mode`=1, `cd_in` replaces `ext_sync` as the sync source, and `ext_sync` is ignored. With `cd_late`=0, the bit on which `cd_in` is seen is the first data bit.
- R11: With `cd_mode`=1 and `cd_late`=1, `cd_in` is asserted on the second bit of the frame. The bit received just before it is the first data bit.
- R12: Cycles with `bit_valid`=0 are ignored: they do not align, shift or complete a byte, whatever `bit_in`, `ext_sync` and `cd_in` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Receiver enable; 0 forces hunting |
| len_sel | input | 2 | Sync source: 00 external, 01 4-bit, 10 8-bit, 11 16-bit |
| sync_pat | input | 16 | Sync pattern word |
| strip_en | input | 1 | Drop repeated sync nibbles in 4-bit mode |
| cd_mode | input | 1 | Use carrier detect as sync in external mode |
| cd_late | input | 1 | Carrier detect arrives on the second frame bit |
| hunt_cmd | input | 1 | Return to hunting |
| bit_valid | input | 1 | Bit strobe |
| bit_in | input | 1 | Serial data bit |
| ext_sync | input | 1 | External sync marker |
| cd_in | input | 1 | Carrier detect |
| rx_byte | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle strobe for rx_byte |
| aligned | output | 1 | Receiver is past sync |

## Verification
The hardest state to reach is the end of stripping. The bench has to lock in 4-bit mode, feed several back-to-back copies of the sync nibble, then break the run with a different nibble, and then send the pattern again. It builds this with one stream: a lead-in that makes exactly one window match, two repeats, a mismatching byte, and a final byte made of two more pattern nibbles. The same stream is replayed with stripping off, so the two expected byte lists can be compared. The late carrier-detect case is reached by holding `cd_in` low on the first frame bit and raising it on the second, so that the first byte only comes out right if the earlier bit is kept.

// File: rtl/shr_pkg.sv
package shr_pkg;

    localparam int SYNC_W = 16;
    localparam int FILL_W = $clog2(SYNC_W + 1);

    typedef enum logic [1:0] {
        LEN_EXT = 2'b00,
        LEN_4   = 2'b01,
        LEN_8   = 2'b10,
        LEN_16  = 2'b11
    } sync_len_e;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_LOCK = 1'b1
    } rx_state_e;

    function automatic logic [SYNC_W-1:0] len_mask(sync_len_e l);
        case (l)
            LEN_4:   return SYNC_W'(16'h000F);
            LEN_8:   return SYNC_W'(16'h00FF);
            LEN_16:  return {SYNC_W{1'b1}};
            default: return '0;
        endcase
    endfunction

    function automatic logic [FILL_W-1:0] len_bits(sync_len_e l);
        case (l)
            LEN_4:   return FILL_W'(4);
            LEN_8:   return FILL_W'(8);
            LEN_16:  return FILL_W'(16);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/shr_sync_detect.sv
module shr_sync_detect
    import shr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              sh,
    input  logic              bit_in,
    input  sync_len_e         len,
    input  logic [SYNC_W-1:0] pat,
    output logic              match,
    output logic              last_bit
);

    logic [SYNC_W-1:0] hist;
    logic [SYNC_W-1:0] hist_nx;
    logic [FILL_W-1:0] fill;
    logic              enough;

    assign hist_nx  = {hist[SYNC_W-2:0], bit_in};
    assign enough   = (FILL_W'(fill + 1'b1) >= len_bits(len));
    assign match    = sh && (len != LEN_EXT) && enough &&
                      (((hist_nx ^ pat) & len_mask(len)) == '0);
    assign last_bit = hist[0];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            hist <= '0;
            fill <= '0;
        end else if (sh) begin
            hist <= hist_nx;
            if (fill != FILL_W'(SYNC_W))
                fill <= fill + 1'b1;
        end
    end

    assert_fill_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (!sh && !clr) |=> $stable(fill));

endmodule

// File: rtl/shr_byte_packer.sv
module shr_byte_packer #(
    parameter int W   = 8,
    parameter int NIB = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  logic           strip_arm,
    input  logic           ld,
    input  logic           ld_two,
    input  logic [1:0]     ld_bits,
    input  logic           sh,
    input  logic           bit_in,
    input  logic [NIB-1:0] strip_pat,
    output logic [W-1:0]   data_out,
    output logic           data_vld
);

    localparam int CW = $clog2(W);

    logic [W-1:0]  acc;
    logic [W-1:0]  acc_nx;
    logic [CW-1:0] cnt;
    logic          stripping;

    assign acc_nx = {acc[W-2:0], bit_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc       <= '0;
            cnt       <= '0;
            stripping <= 1'b0;
            data_out  <= '0;
            data_vld  <= 1'b0;
        end else begin
            data_vld <= 1'b0;
            if (clr) begin
                acc       <= '0;
                cnt       <= '0;
                stripping <= strip_arm;
            end else if (ld) begin
                acc       <= ld_two ? W'(ld_bits) : W'(ld_bits[0]);
                cnt       <= ld_two ? CW'(2) : CW'(1);
                stripping <= 1'b0;
            end else if (sh) begin
                acc <= acc_nx;
                if (stripping && cnt == CW'(NIB - 1)) begin
                    if (acc_nx[NIB-1:0] == strip_pat) begin
                        cnt <= '0;
                    end else begin
                        stripping <= 1'b0;
                        cnt       <= CW'(NIB);
                    end
                end else if (cnt == CW'(W - 1)) begin
                    data_out <= acc_nx;
                    data_vld <= 1'b1;
                    cnt      <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assert_vld_single_R6: assert property (@(posedge clk) disable iff (rst)
        data_vld |=> !data_vld);

    assert_cnt_idle_R12: assert property (@(posedge clk) disable iff (rst)
        (!sh && !ld && !clr) |=> $stable(cnt));

    assert_strip_no_rearm_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(stripping) |-> $past(clr));

endmodule

// File: rtl/sync_hunt_rx.sv
module sync_hunt_rx
    import shr_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [1:0]        len_sel,
    input  logic [SYNC_W-1:0] sync_pat,
    input  logic              strip_en,
    input  logic              cd_mode,
    input  logic              cd_late,
    input  logic              hunt_cmd,
    input  logic              bit_valid,
    input  logic              bit_in,
    input  logic              ext_sync,
    input  logic              cd_in,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              aligned
);

    rx_state_e state;
    sync_len_e len;
    logic      sync_sig;
    logic      ext_hit;
    logic      pat_hit;
    logic      lock_now;
    logic      drop;
    logic      last_bit;
    logic      pk_clr;
    logic      pk_ld;
    logic      pk_sh;

    assign len      = sync_len_e'(len_sel);
    assign sync_sig = cd_mode ? cd_in : ext_sync;
    assign drop     = !en || hunt_cmd;
    assign ext_hit  = bit_valid && (len == LEN_EXT) && sync_sig;
    assign lock_now = (state == ST_HUNT) && !drop && (pat_hit || ext_hit);
    assign pk_ld    = lock_now && ext_hit;
    assign pk_clr   = drop || ((state == ST_HUNT) && !pk_ld);
    assign pk_sh    = (state == ST_LOCK) && !drop && bit_valid;
    assign aligned  = (state == ST_LOCK);

    shr_sync_detect u_det (
        .clk      (clk),
        .rst      (rst),
        .clr      (!en),
        .sh       (bit_valid && en),
        .bit_in   (bit_in),
        .len      (len),
        .pat      (sync_pat),
        .match    (pat_hit),
        .last_bit (last_bit)
    );

    shr_byte_packer #(.W(BYTE_W), .NIB(NIB_W)) u_pack (
        .clk       (clk),
        .rst       (rst),
        .clr       (pk_clr),
        .strip_arm (strip_en && (len == LEN_4)),
        .ld        (pk_ld),
        .ld_two    (cd_mode && cd_late),
        .ld_bits   ({last_bit, bit_in}),
        .sh        (pk_sh),
        .bit_in    (bit_in),
        .strip_pat (sync_pat[NIB_W-1:0]),
        .data_out  (rx_byte),
        .data_vld  (rx_valid)
    );

    always_ff @(posedge clk) begin
        if (rst)           state <= ST_HUNT;
        else if (drop)     state <= ST_HUNT;
        else if (lock_now) state <= ST_LOCK;
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!aligned && !rx_valid));

    assert_drop_hunts_R7: assert property (@(posedge clk) disable iff (rst)
        drop |=> !aligned);

    assert_lock_on_strobe_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(aligned) |-> $past(bit_valid));

    assert_valid_when_locked_R6: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(aligned));

endmodule

// File: tb/sim_sync_hunt_rx.sv
module sim_sync_hunt_rx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [1:0]  len_sel = 2'b00;
    logic [15:0] sync_pat = 16'h0000;
    logic        strip_en = 1'b0;
    logic        cd_mode = 1'b0;
    logic        cd_late = 1'b0;
    logic        hunt_cmd = 1'b0;
    logic        bit_valid = 1'b0;
    logic        bit_in = 1'b0;
    logic        ext_sync = 1'b0;
    logic        cd_in = 1'b0;
    logic [7:0]  rx_byte;
    logic        rx_valid;
    logic        aligned;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] rx_buf [0:15];
    int rx_n = 0;

    always #10 clk = ~clk;

    sync_hunt_rx u0 (
        .clk(clk), .rst(rst), .en(en), .len_sel(len_sel), .sync_pat(sync_pat),
        .strip_en(strip_en), .cd_mode(cd_mode), .cd_late(cd_late),
        .hunt_cmd(hunt_cmd), .bit_valid(bit_valid), .bit_in(bit_in),
        .ext_sync(ext_sync), .cd_in(cd_in), .rx_byte(rx_byte),
        .rx_valid(rx_valid), .aligned(aligned)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic grab();
        #1;
        if (rx_valid && rx_n < 16) begin
            rx_buf[rx_n] = rx_byte;
            rx_n++;
        end
    endtask

    task automatic send_bit(input logic b, input logic es, input logic cd);
        @(negedge clk);
        bit_valid = 1'b1; bit_in = b; ext_sync = es; cd_in = cd;
        @(posedge clk);
        grab();
        @(negedge clk);
        bit_valid = 1'b0; ext_sync = 1'b0; cd_in = 1'b0;
    endtask

    task automatic idle(input logic b, input logic es, input logic cd);
        @(negedge clk);
        bit_valid = 1'b0; bit_in = b; ext_sync = es; cd_in = cd;
        @(posedge clk);
        grab();
        @(negedge clk);
        ext_sync = 1'b0; cd_in = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i], 1'b0, 1'b0);
    endtask

    task automatic send_nib(input logic [3:0] v);
        for (int i = 3; i >= 0; i--) send_bit(v[i], 1'b0, 1'b0);
    endtask

    task automatic restart(input logic [1:0] l, input logic [15:0] p);
        @(negedge clk);
        rst = 1'b1; en = 1'b1; len_sel = l; sync_pat = p;
        strip_en = 1'b0; cd_mode = 1'b0; cd_late = 1'b0; hunt_cmd = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        rx_n = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #1;
        chk("R1 aligned after reset", aligned, 0);
        chk("R1 rx_valid after reset", rx_valid, 0);
    endtask

    task automatic t_ext();
        restart(2'b00, 16'hFFFF);
        send_byte(8'hFF);
        chk("R2 no lock without ext_sync", aligned, 0);
        idle(1'b1, 1'b1, 1'b0);
        chk("R12 idle ext_sync ignored", aligned, 0);
        send_bit(1'b1, 1'b1, 1'b0);
        chk("R2 lock on ext_sync", aligned, 1);
        send_bit(1'b0, 1'b0, 1'b0);
        idle(1'b1, 1'b0, 1'b0);
        idle(1'b0, 1'b1, 1'b0);
        for (int i = 5; i >= 0; i--) send_bit(((8'hA5 >> i) & 1) != 0, 1'b0, 1'b0);
        send_byte(8'h3C);
        chk("R12 gap byte count", rx_n, 2);
        chk("R2 first byte", rx_buf[0], 8'hA5);
        chk("R6 second byte", rx_buf[1], 8'h3C);
    endtask

    task automatic t_pat4();
        restart(2'b01, 16'hA55B);
        send_nib(4'h0);
        send_nib(4'hB);
        chk("R3 lock on nibble", aligned, 1);
        send_byte(8'h5A);
        chk("R3 byte count", rx_n, 1);
        chk("R3 byte after sync", rx_buf[0], 8'h5A);
    endtask

    task automatic t_pat8();
        restart(2'b10, 16'h117E);
        send_byte(8'h00);
        chk("R4 hunting before pattern", aligned, 0);
        send_byte(8'h7E);
        chk("R4 lock on byte", aligned, 1);
        send_byte(8'hC3);
        send_byte(8'h81);
        send_byte(8'h7E);
        chk("R7 still aligned after pattern in data", aligned, 1);
        chk("R4 byte count", rx_n, 3);
        chk("R4 byte 0", rx_buf[0], 8'hC3);
        chk("R6 byte 1", rx_buf[1], 8'h81);
        chk("R7 pattern as data", rx_buf[2], 8'h7E);
        @(negedge clk); hunt_cmd = 1'b1;
        @(posedge clk); #1;
        chk("R7 hunt_cmd drops lock", aligned, 0);
        @(negedge clk); hunt_cmd = 1'b0;
        send_byte(8'h7E);
        chk("R7 relock", aligned, 1);
        @(negedge clk); en = 1'b0;
        @(posedge clk); #1;
        chk("R7 disable drops lock", aligned, 0);
        @(negedge clk); en = 1'b1;
    endtask

    task automatic t_pat16();
        restart(2'b11, 16'hF628);
        send_byte(8'h28);
        chk("R5 no lock on low byte", aligned, 0);
        send_byte(8'h00);
        send_byte(8'hF6);
        chk("R5 partial pattern", aligned, 0);
        send_byte(8'h28);
        chk("R5 lock on 16 bits", aligned, 1);
        send_byte(8'h11);
        chk("R5 byte", rx_buf[0], 8'h11);
        restart(2'b11, 16'h0000);
        send_byte(8'h00);
        chk("R5 needs full length", aligned, 0);
        send_byte(8'h00);
        chk("R5 lock after 16 bits", aligned, 1);
    endtask

    task automatic strip_stream();
        send_nib(4'h0);
        send_nib(4'h6);
        send_nib(4'h6);
        send_nib(4'h6);
        send_byte(8'h93);
        send_byte(8'h66);
    endtask

    task automatic t_strip();
        restart(2'b01, 16'h0006);
        strip_en = 1'b1;
        strip_stream();
        chk("R8 stripped byte count", rx_n, 2);
        chk("R8 first byte after strip", rx_buf[0], 8'h93);
        chk("R9 pattern after stop", rx_buf[1], 8'h66);
        restart(2'b01, 16'h0006);
        strip_stream();
        chk("R8 no strip count", rx_n, 3);
        chk("R8 no strip byte 0", rx_buf[0], 8'h66);
        chk("R8 no strip byte 1", rx_buf[1], 8'h93);
    endtask

    task automatic t_cd();
        restart(2'b00, 16'h0000);
        cd_mode = 1'b1;
        send_bit(1'b1, 1'b1, 1'b0);
        chk("R10 ext_sync ignored", aligned, 0);
        send_bit(1'b1, 1'b0, 1'b1);
        chk("R10 lock on cd", aligned, 1);
        for (int i = 6; i >= 0; i--) send_bit(((8'hB4 >> i) & 1) != 0, 1'b0, 1'b0);
        chk("R10 byte", rx_buf[0], 8'hB4);
        restart(2'b00, 16'h0000);
        cd_mode = 1'b1; cd_late = 1'b1;
        send_bit(1'b0, 1'b0, 1'b0);
        send_bit(1'b1, 1'b0, 1'b0);
        send_bit(1'b1, 1'b0, 1'b1);
        chk("R11 lock on second bit", aligned, 1);
        for (int i = 5; i >= 0; i--) send_bit(((8'hD2 >> i) & 1) != 0, 1'b0, 1'b0);
        chk("R11 byte count", rx_n, 1);
        chk("R11 byte", rx_buf[0], 8'hD2);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_ext();
        t_pat4();
        t_pat8();
        t_pat16();
        t_strip();
        t_cd();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule